// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Burst Fill

This block sits between an instruction fetch unit and a 32-bit burst memory bus and holds recently fetched instruction words. The fetch side hands over a word address; the cache answers one cycle after acceptance with the 32-bit instruction word and a valid strobe. Storage is 512 bytes, direct-mapped, as 32 lines of four 32-bit words. Writes, data caching and coherence are not handled.

When a fetch misses, the cache claims the line, raises a burst request for the line-aligned address and takes four beats, always starting at word 0. Each beat is written into the line. The beat that carries the requested word is also passed to the decoder on the following cycle, so the array is never re-read. The line is marked valid only after the fourth beat. Once the requested word has been delivered, the fetch unit may read words of the filling line that have already arrived. A synchronous invalidate-all input clears every valid bit in one cycle.

Top module: `icache_dm`

## Requirements
- R1: After reset, `fetch_ready` is 1, `insn_valid` and `bus_req` are 0, and every line is invalid, so the first fetch misses.
- R2: A fetch accepted while idle whose line is valid with a matching tag gives `insn_valid` on the next cycle with the stored word. No bus request follows.
- R3: A miss raises `bus_req` on the cycle after acceptance, with `bus_addr` equal to the fetch address with bits [3:0] cleared. `bus_req` and `bus_addr` stay unchanged until the fourth beat. `bus_req` is 0 on the cycle after the fourth beat.
- R4: Beat k of a burst (k = 0..3, counted by `bus_rdy` pulses) is stored as word k of the line. Later hits to word k return that beat's data.
- R5: On a miss, `insn_valid` is 1 on the cycle after the beat that carries the requested word, and `insn_data` equals that beat's `bus_data`. No other beat produces a response.
- R6: `fetch_waddr` is a word address. Bits [1:0] select the word in a line, bits [6:2] select the line index and bits [29:7] form the tag. Two addresses with the same index and different tags evict each other. Different indexes coexist.
- R7: During a fill, `fetch_ready` is 0 until the requested word has been delivered.
- R8: After delivery and before the fourth beat, `fetch_ready` is 1 only for a fetch to the filling line whose word has already arrived. Such a fetch returns that word one cycle later.
- R9: A filled line becomes valid only after its fourth beat. After that, fetches to any of its words hit.
- R10: While `inval_all` is 1, `fetch_ready` is 0 and the fetch is ignored: no response and no bus request follow. From the next cycle on, every line is invalid.
- R11: If `inval_all` is 1 during a fill, including the cycle of the fourth beat, the burst still completes and the requested word is still delivered. The line is not valid afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inval_all | input | 1 | Clear all valid bits this cycle |
| fetch_valid | input | 1 | Fetch request present |
| fetch_waddr | input | 30 | Word address of the instruction |
| fetch_ready | output | 1 | Fetch accepted at this edge when high with fetch_valid |
| insn_valid | output | 1 | Instruction word valid |
| insn_data | output | 32 | Instruction word |
| bus_req | output | 1 | Burst read request, held for the whole burst |
| bus_addr | output | 32 | Line-aligned burst address |
| bus_rdy | input | 1 | One burst beat on bus_data this cycle |
| bus_data | input | 32 | Burst beat data |

## Verification
Two pairs of events can land in the same cycle. The first is the fourth burst beat, which would mark the line valid, together with `inval_all`. The second is a read of an already-received word of the filling line together with the rest of the fill. The bench drives `inval_all` exactly on the final `bus_rdy` beat, then refetches the same word and requires a fresh burst, since invalidation must win. Between beats it issues reads of received and not-yet-received words and judges `fetch_ready` and the returned data against a reference model of line validity and memory contents.

// File: rtl/icache_pkg.sv
package icache_pkg;
    // Byte offset inside one 32-bit instruction word.
    localparam int BYTE_OFF_W = 2;

    // Line-aligned byte address built from the tag and index fields.
    function automatic logic [63:0] line_base(input logic [63:0] tag_idx, input int low_w);
        return tag_idx << low_w;
    endfunction
endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store
    import icache_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int TAG_W     = 23
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         inval_all,
    input  logic [$clog2(NUM_LINES)-1:0] rd_idx,
    output logic                         rd_valid,
    output logic [TAG_W-1:0]             rd_tag,
    input  logic                         alloc_en,
    input  logic [$clog2(NUM_LINES)-1:0] alloc_idx,
    input  logic [TAG_W-1:0]             alloc_tag,
    input  logic                         seal_en,
    input  logic [$clog2(NUM_LINES)-1:0] seal_idx
);
    localparam int IDX_W = $clog2(NUM_LINES);

    typedef struct packed {
        logic [NUM_LINES-1:0]            valid;
        logic [NUM_LINES-1:0][TAG_W-1:0] tag;
    } tag_state_t;

    tag_state_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (alloc_en) begin
            t_d.tag[alloc_idx]   = alloc_tag;
            t_d.valid[alloc_idx] = 1'b0;
        end
        if (seal_en) begin
            t_d.valid[seal_idx] = 1'b1;
        end
        if (inval_all) begin
            t_d.valid = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign rd_valid = t_q.valid[rd_idx];
    assign rd_tag   = t_q.tag[rd_idx];

    // R10
    inval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all |=> (t_q.valid == '0));

    // R9
    seal_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seal_en && !inval_all) |=> t_q.valid[$past(seal_idx)]);

    // R3
    alloc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && !seal_en) |=> !t_q.valid[$past(alloc_idx)]);

    logic [IDX_W-1:0] unused_w;
    assign unused_w = '0;
endmodule

// File: rtl/icache_data_store.sv
module icache_data_store #(
    parameter int NUM_LINES  = 32,
    parameter int LINE_WORDS = 4,
    parameter int DATA_W     = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(NUM_LINES)-1:0]  rd_idx,
    input  logic [$clog2(LINE_WORDS)-1:0] rd_word,
    output logic [DATA_W-1:0]             rd_data,
    input  logic                          wr_en,
    input  logic [$clog2(NUM_LINES)-1:0]  wr_idx,
    input  logic [$clog2(LINE_WORDS)-1:0] wr_word,
    input  logic [DATA_W-1:0]             wr_data
);
    logic [LINE_WORDS-1:0][DATA_W-1:0] col_rd;

    // One storage column per word position inside a line.
    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_col
        logic [NUM_LINES-1:0][DATA_W-1:0] col_d, col_q;

        always_comb begin
            col_d = col_q;
            if (wr_en && wr_word == w) begin
                col_d[wr_idx] = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                col_q <= '0;
            end else begin
                col_q <= col_d;
            end
        end

        assign col_rd[w] = col_q[rd_idx];

        // R4
        col_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_word == w) |=> (col_q[$past(wr_idx)] == $past(wr_data)));
    end

    assign rd_data = col_rd[rd_word];
endmodule

// File: rtl/icache_fill_ctrl.sv
module icache_fill_ctrl
    import icache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int NUM_LINES  = 32
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   inval_all,
    input  logic                                   req_valid,
    input  logic [ADDR_W-BYTE_OFF_W-$clog2(LINE_WORDS)-$clog2(NUM_LINES)-1:0] req_tag,
    input  logic [$clog2(NUM_LINES)-1:0]           req_idx,
    input  logic [$clog2(LINE_WORDS)-1:0]          req_word,
    output logic                                   req_ready,
    input  logic                                   lkp_hit,
    input  logic [DATA_W-1:0]                      lkp_data,
    output logic                                   rsp_valid,
    output logic [DATA_W-1:0]                      rsp_data,
    output logic                                   mem_req,
    output logic [ADDR_W-1:0]                      mem_addr,
    input  logic                                   mem_rdy,
    input  logic [DATA_W-1:0]                      mem_data,
    output logic                                   alloc_en,
    output logic [$clog2(NUM_LINES)-1:0]           alloc_idx,
    output logic [ADDR_W-BYTE_OFF_W-$clog2(LINE_WORDS)-$clog2(NUM_LINES)-1:0] alloc_tag,
    output logic                                   seal_en,
    output logic [$clog2(NUM_LINES)-1:0]           seal_idx,
    output logic                                   wr_en,
    output logic [$clog2(NUM_LINES)-1:0]           wr_idx,
    output logic [$clog2(LINE_WORDS)-1:0]          wr_word,
    output logic [DATA_W-1:0]                      wr_data
);
    localparam int WORD_W = $clog2(LINE_WORDS);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int LOW_W  = WORD_W + BYTE_OFF_W;
    localparam int TAG_W  = ADDR_W - LOW_W - IDX_W;
    localparam logic [WORD_W-1:0] LAST_BEAT = WORD_W'(LINE_WORDS - 1);

    typedef struct packed {
        logic              busy;
        logic              crit_pend;
        logic              stale;
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] crit;
        logic [WORD_W-1:0] cnt;
        logic              rsp_v;
        logic [DATA_W-1:0] rsp_d;
    } fill_state_t;

    fill_state_t s_d, s_q;

    logic partial_hit;
    logic accept;
    logic beat;
    logic last_beat;

    always_comb begin
        partial_hit = s_q.busy && !s_q.crit_pend && (req_tag == s_q.tag) &&
                      (req_idx == s_q.idx) && (req_word < s_q.cnt);
        req_ready   = !inval_all && (!s_q.busy || partial_hit);
        accept      = req_valid && req_ready;
        beat        = s_q.busy && mem_rdy;
        last_beat   = beat && (s_q.cnt == LAST_BEAT);

        s_d       = s_q;
        s_d.rsp_v = 1'b0;
        alloc_en  = 1'b0;
        seal_en   = 1'b0;
        wr_en     = 1'b0;

        if (accept) begin
            if (s_q.busy || lkp_hit) begin
                s_d.rsp_v = 1'b1;
                s_d.rsp_d = lkp_data;
            end else begin
                s_d.busy      = 1'b1;
                s_d.crit_pend = 1'b1;
                s_d.stale     = 1'b0;
                s_d.tag       = req_tag;
                s_d.idx       = req_idx;
                s_d.crit      = req_word;
                s_d.cnt       = '0;
                alloc_en      = 1'b1;
            end
        end

        if (beat) begin
            wr_en = 1'b1;
            if (s_q.crit_pend && s_q.cnt == s_q.crit) begin
                s_d.rsp_v     = 1'b1;
                s_d.rsp_d     = mem_data;
                s_d.crit_pend = 1'b0;
            end
            s_d.cnt = s_q.cnt + WORD_W'(1);
            if (last_beat) begin
                s_d.busy = 1'b0;
                seal_en  = !s_q.stale && !inval_all;
            end
        end

        if (inval_all && s_q.busy) begin
            s_d.stale = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign alloc_idx = req_idx;
    assign alloc_tag = req_tag;
    assign seal_idx  = s_q.idx;
    assign wr_idx    = s_q.idx;
    assign wr_word   = s_q.cnt;
    assign wr_data   = mem_data;
    assign rsp_valid = s_q.rsp_v;
    assign rsp_data  = s_q.rsp_d;
    assign mem_req   = s_q.busy;
    assign mem_addr  = ADDR_W'(line_base(64'({s_q.tag, s_q.idx}), LOW_W));

    // R3
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !last_beat) |=> (mem_req && $stable(mem_addr)));

    // R3
    burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |=> !mem_req);

    // R5
    crit_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && s_q.crit_pend && s_q.cnt == s_q.crit) |=>
            (rsp_valid && rsp_data == $past(mem_data)));

    // R7
    pend_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !s_q.busy && !lkp_hit) |=> !req_ready);
endmodule

// File: rtl/icache_dm.sv
module icache_dm
    import icache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int NUM_LINES  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     inval_all,
    input  logic                     fetch_valid,
    input  logic [ADDR_W-BYTE_OFF_W-1:0] fetch_waddr,
    output logic                     fetch_ready,
    output logic                     insn_valid,
    output logic [DATA_W-1:0]        insn_data,
    output logic                     bus_req,
    output logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_rdy,
    input  logic [DATA_W-1:0]        bus_data
);
    localparam int WA_W   = ADDR_W - BYTE_OFF_W;
    localparam int WORD_W = $clog2(LINE_WORDS);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int TAG_W  = WA_W - WORD_W - IDX_W;

    logic [WORD_W-1:0] f_word;
    logic [IDX_W-1:0]  f_idx;
    logic [TAG_W-1:0]  f_tag;

    assign f_word = fetch_waddr[WORD_W-1:0];
    assign f_idx  = fetch_waddr[WORD_W +: IDX_W];
    assign f_tag  = fetch_waddr[WA_W-1 -: TAG_W];

    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [DATA_W-1:0] rd_data;
    logic              lkp_hit;
    logic              alloc_en;
    logic [IDX_W-1:0]  alloc_idx;
    logic [TAG_W-1:0]  alloc_tag;
    logic              seal_en;
    logic [IDX_W-1:0]  seal_idx;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [WORD_W-1:0] wr_word;
    logic [DATA_W-1:0] wr_data;

    assign lkp_hit = rd_valid && (rd_tag == f_tag);

    icache_tag_store #(
        .NUM_LINES (NUM_LINES),
        .TAG_W     (TAG_W)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .inval_all (inval_all),
        .rd_idx    (f_idx),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .alloc_en  (alloc_en),
        .alloc_idx (alloc_idx),
        .alloc_tag (alloc_tag),
        .seal_en   (seal_en),
        .seal_idx  (seal_idx)
    );

    icache_data_store #(
        .NUM_LINES  (NUM_LINES),
        .LINE_WORDS (LINE_WORDS),
        .DATA_W     (DATA_W)
    ) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (f_idx),
        .rd_word (f_word),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_word (wr_word),
        .wr_data (wr_data)
    );

    icache_fill_ctrl #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .LINE_WORDS (LINE_WORDS),
        .NUM_LINES  (NUM_LINES)
    ) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .inval_all (inval_all),
        .req_valid (fetch_valid),
        .req_tag   (f_tag),
        .req_idx   (f_idx),
        .req_word  (f_word),
        .req_ready (fetch_ready),
        .lkp_hit   (lkp_hit),
        .lkp_data  (rd_data),
        .rsp_valid (insn_valid),
        .rsp_data  (insn_data),
        .mem_req   (bus_req),
        .mem_addr  (bus_addr),
        .mem_rdy   (bus_rdy),
        .mem_data  (bus_data),
        .alloc_en  (alloc_en),
        .alloc_idx (alloc_idx),
        .alloc_tag (alloc_tag),
        .seal_en   (seal_en),
        .seal_idx  (seal_idx),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_word   (wr_word),
        .wr_data   (wr_data)
    );

    // R2
    hit_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_ready && !bus_req && lkp_hit) |=> (insn_valid && !bus_req));

    // R10
    inval_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inval_all && !bus_req) |=> (!insn_valid && !bus_req));
endmodule

// File: tb/sim_icache_dm.sv
`timescale 1ns/1ps
module sim_icache_dm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inval_all = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [29:0] fetch_waddr = '0;
    logic        fetch_ready;
    logic        insn_valid;
    logic [31:0] insn_data;
    logic        bus_req;
    logic [31:0] bus_addr;
    logic        bus_rdy = 1'b0;
    logic [31:0] bus_data = '0;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [31:0] mvalid;
    logic [22:0] mtag [32];

    always #2.5 clk = ~clk;

    icache_dm u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .inval_all   (inval_all),
        .fetch_valid (fetch_valid),
        .fetch_waddr (fetch_waddr),
        .fetch_ready (fetch_ready),
        .insn_valid  (insn_valid),
        .insn_data   (insn_data),
        .bus_req     (bus_req),
        .bus_addr    (bus_addr),
        .bus_rdy     (bus_rdy),
        .bus_data    (bus_data)
    );

    // Memory contents seen on the bus, a function of the word address.
    function automatic logic [31:0] mem_word(input logic [29:0] wa);
        return ({2'b00, wa} * 32'h9E3779B1) ^ 32'h1234_5678;
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // One fetch. inval_beat: beat number during which inval_all is raised (-1 none).
    task automatic do_fetch(input logic [29:0] wa, input int inval_beat, input bit probe);
        logic [4:0]  idx = wa[6:2];
        logic [22:0] tg  = wa[29:7];
        int          w   = int'(wa[1:0]);
        bit          hit = mvalid[idx] && (mtag[idx] == tg);
        bit          stale = 1'b0;
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_waddr = wa;
        chk("R8 ready when idle", {31'd0, fetch_ready}, 32'd1);
        @(negedge clk);
        fetch_valid = 1'b0;
        if (hit) begin
            chk("R2 hit valid", {31'd0, insn_valid}, 32'd1);
            chk("R2 hit data", insn_data, mem_word(wa));
            chk("R2 no bus on hit", {31'd0, bus_req}, 32'd0);
        end else begin
            mvalid[idx] = 1'b0;
            chk("R3 req raised", {31'd0, bus_req}, 32'd1);
            chk("R3 line address", bus_addr, {wa[29:2], 4'b0000});
            chk("R7 ready held off", {31'd0, fetch_ready}, 32'd0);
            chk("R5 no early rsp", {31'd0, insn_valid}, 32'd0);
            for (int k = 0; k < 4; k++) begin
                int gap = int'($urandom_range(0, 2));
                for (int g = 0; g < gap; g++) begin
                    bus_rdy = 1'b0;
                    @(negedge clk);
                    chk("R3 req held", {31'd0, bus_req}, 32'd1);
                end
                bus_rdy  = 1'b1;
                bus_data = mem_word({wa[29:2], 2'(k)});
                if (k == inval_beat) begin
                    inval_all = 1'b1;
                    stale = 1'b1;
                    mvalid = '0;
                end
                @(negedge clk);
                bus_rdy   = 1'b0;
                bus_data  = 32'hDEAD_BEEF;
                inval_all = 1'b0;
                if (k == w) begin
                    chk("R5 forwarded valid", {31'd0, insn_valid}, 32'd1);
                    chk("R5 forwarded data", insn_data, mem_word(wa));
                end else begin
                    chk("R5 no rsp on other beat", {31'd0, insn_valid}, 32'd0);
                end
                if (k < 3) begin
                    chk("R3 req held", {31'd0, bus_req}, 32'd1);
                    if (probe && k >= w) begin
                        logic [1:0] j = 2'($urandom_range(0, k));
                        fetch_valid = 1'b1;
                        fetch_waddr = {wa[29:2], 2'(k + 1)};
                        #0.5;
                        chk("R8 unreceived word blocked", {31'd0, fetch_ready}, 32'd0);
                        fetch_waddr = {wa[29:2], j};
                        #0.5;
                        chk("R8 received word ready", {31'd0, fetch_ready}, 32'd1);
                        @(negedge clk);
                        fetch_valid = 1'b0;
                        chk("R8 partial hit valid", {31'd0, insn_valid}, 32'd1);
                        chk("R8 partial hit data", insn_data, mem_word({wa[29:2], j}));
                    end
                end
            end
            chk("R3 req dropped", {31'd0, bus_req}, 32'd0);
            if (!stale) begin
                mvalid[idx] = 1'b1;
                mtag[idx] = tg;
            end
        end
    endtask

    task automatic do_inval(input logic [29:0] wa);
        @(negedge clk);
        inval_all = 1'b1;
        fetch_valid = 1'b1;
        fetch_waddr = wa;
        #0.5;
        chk("R10 ready low during inval", {31'd0, fetch_ready}, 32'd0);
        @(negedge clk);
        inval_all = 1'b0;
        fetch_valid = 1'b0;
        chk("R10 ignored fetch no rsp", {31'd0, insn_valid}, 32'd0);
        chk("R10 ignored fetch no bus", {31'd0, bus_req}, 32'd0);
        mvalid = '0;
    endtask

    // Expects the next fetch to wa to start a burst, then completes it.
    task automatic expect_miss(input string rq, input logic [29:0] wa);
        logic [4:0] idx = wa[6:2];
        bit hit = mvalid[idx] && (mtag[idx] == wa[29:7]);
        chk(rq, {31'd0, hit}, 32'd0);
        do_fetch(wa, -1, 1'b0);
    endtask

    initial begin
        logic [22:0] pool [3];
        pool[0] = 23'h000001;
        pool[1] = 23'h0002A5;
        pool[2] = 23'h7FFFFF;
        mvalid = '0;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", {31'd0, fetch_ready}, 32'd1);
        chk("R1 no rsp after reset", {31'd0, insn_valid}, 32'd0);
        chk("R1 no bus after reset", {31'd0, bus_req}, 32'd0);

        // R1 first fetch misses; R4 all four words land in place.
        do_fetch({23'h000001, 5'd3, 2'd2}, -1, 1'b1);
        for (int k = 0; k < 4; k++) do_fetch({23'h000001, 5'd3, 2'(k)}, -1, 1'b0);
        chk("R9 line valid after fill", {31'd0, mvalid[3]}, 32'd1);

        // R6 same index, other tag evicts; other index coexists.
        do_fetch({23'h0002A5, 5'd3, 2'd0}, -1, 1'b0);
        do_fetch({23'h000001, 5'd4, 2'd1}, -1, 1'b0);
        expect_miss("R6 evicted line misses", {23'h000001, 5'd3, 2'd1});
        do_fetch({23'h000001, 5'd4, 2'd3}, -1, 1'b0);

        // R11 invalidate on the final beat: line must stay invalid.
        do_fetch({23'h7FFFFF, 5'd9, 2'd0}, 3, 1'b0);
        expect_miss("R11 line invalid after inval on last beat", {23'h7FFFFF, 5'd9, 2'd0});
        // R11 invalidate mid-burst with a critical word late in the line.
        do_fetch({23'h000001, 5'd10, 2'd3}, 1, 1'b1);
        expect_miss("R11 line invalid after mid-fill inval", {23'h000001, 5'd10, 2'd3});

        // R10 invalidate while idle drops all lines.
        do_inval({23'h000001, 5'd10, 2'd3});
        expect_miss("R10 miss after inval", {23'h000001, 5'd10, 2'd0});

        for (int i = 0; i < 250; i++) begin
            int r = int'($urandom_range(0, 9));
            logic [29:0] wa = {pool[$urandom_range(0, 2)], 5'($urandom_range(0, 7)),
                               2'($urandom_range(0, 3))};
            if (r == 0) begin
                do_inval(wa);
            end else begin
                int ib = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 3)) : -1;
                do_fetch(wa, ib, 1'($urandom_range(0, 1)));
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule